// File: doc/BRIEF.md
# Accumulator-Based Two-Phase Processor

This block is a small stored-program processor. It has one 16-bit accumulator, a 12-bit program counter and a register that holds the current instruction. Instructions and data share a single word-addressed memory port. Each word on that port is 16 bits wide. The memory sits outside the block. It is modelled as combinational: read data for the address driven in a cycle is valid in that same cycle, and a write takes effect at the next rising clock edge.

The processor spends one cycle per memory access. An instruction that names a memory operand takes two cycles: a fetch-and-decode cycle, then an operand cycle that reads or writes the addressed word. Jumps and the stop instruction need only the fetch, so they complete in a single cycle. After a stop the processor raises its halted output. It stays frozen until reset, and reset always restarts execution at word 0.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the processor returns to its initial state: program counter 0, accumulator 0, `halted` low and `mem_we` low. Execution then begins with a fetch from address 0.
- R2: An instruction word carries its opcode in bits 15:12 and a direct word address in bits 11:0. The opcode map is: 0 load, 1 store, 2 add, 3 subtract, 4 jump, 5 jump-if-non-negative, 6 jump-if-non-zero, 7 stop. During a fetch cycle the program counter is on `mem_addr`. When the fetched instruction is not a taken jump and not a stop, the next fetch comes from the program counter plus 1.
- R3: Load, add and subtract take exactly two cycles. In the second cycle `mem_addr` equals the instruction's address field, and the accumulator becomes, respectively, the read word, the sum, or the accumulator minus the read word. Both arithmetic results wrap modulo 2^16.
- R4: A store takes two cycles. `mem_we` is high only in its second cycle, with the address field on `mem_addr` and the accumulator on `mem_wdata`. `mem_we` is low in every other cycle.
- R5: A jump (opcode 4) takes one cycle. The next fetch comes from its address field.
- R6: Jump-if-non-negative (opcode 5) takes one cycle. It jumps to its address field when accumulator bit 15 is 0. Otherwise the next fetch comes from the program counter plus 1.
- R7: Jump-if-non-zero (opcode 6) takes one cycle. It jumps to its address field when the accumulator is not zero. Otherwise the next fetch comes from the program counter plus 1.
- R8: Stop (opcode 7), and every opcode from 8 to 15, takes one cycle. From the next cycle on, `halted` is high, `mem_addr` holds the address of the stop word, and `mem_we` stays low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 12 | Word address for the fetch or the operand access |
| mem_wdata | output | 16 | Accumulator value offered for a store |
| mem_we | output | 1 | Write strobe, high only in the operand cycle of a store |
| mem_rdata | input | 16 | Word read from `mem_addr`, valid in the same cycle |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
All results are due at known points. A fetch cycle puts the program counter on the address bus at once. The operand address and the store strobe appear in the cycle right after the fetch edge. An accumulator update becomes visible one edge after the operand cycle, through the next store or the next conditional jump. `halted` rises one edge after the stop word is fetched. The bench advances a behavioural model by exactly one edge per clock. It compares address, strobe, write data and `halted` at every falling edge, so every result is checked in the cycle it is due and never later. Memory contents written by stores are checked against values worked out by hand once each program has halted.

// File: rtl/acc_cpu_pkg.sv
// Package: shared widths, opcode encoding and control types for the
// accumulator processor. Assumes a 4-bit opcode above a direct address.
package acc_cpu_pkg;
    parameter int DATA_W = 16;
    parameter int ADDR_W = 12;
    localparam int OPC_W = DATA_W - ADDR_W;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 4'd0,
        OP_STORE = 4'd1,
        OP_ADD   = 4'd2,
        OP_SUB   = 4'd3,
        OP_JMP   = 4'd4,
        OP_JGE   = 4'd5,
        OP_JNZ   = 4'd6,
        OP_STOP  = 4'd7
    } opcode_t;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_SUB  = 2'd2
    } alu_sel_t;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_HALT  = 2'd2
    } cpu_state_t;
endpackage

// File: rtl/acc_cpu_decode.sv
// Decoder: turns an instruction word and the current accumulator into
// control signals. Purely combinational. Assumes opcodes 8..15 mean stop.
module acc_cpu_decode
    import acc_cpu_pkg::*;
(
    input  logic [DATA_W-1:0] instr,
    input  logic [DATA_W-1:0] acc,
    output logic              is_mem,
    output logic              is_store,
    output logic              jump_take,
    output logic              is_stop,
    output alu_sel_t          alu_sel
);
    logic [OPC_W-1:0] opc;
    assign opc = instr[DATA_W-1:ADDR_W];

    // Classify the opcode and decide whether a jump is taken.
    always_comb begin
        is_mem    = 1'b0;
        is_store  = 1'b0;
        jump_take = 1'b0;
        is_stop   = 1'b0;
        alu_sel   = ALU_PASS;
        case (opc)
            OP_LOAD:  begin is_mem = 1'b1; alu_sel = ALU_PASS; end
            OP_STORE: begin is_mem = 1'b1; is_store = 1'b1; end
            OP_ADD:   begin is_mem = 1'b1; alu_sel = ALU_ADD; end
            OP_SUB:   begin is_mem = 1'b1; alu_sel = ALU_SUB; end
            OP_JMP:   jump_take = 1'b1;
            OP_JGE:   jump_take = ~acc[DATA_W-1];
            OP_JNZ:   jump_take = |acc;
            default:  is_stop = 1'b1;
        endcase
    end
endmodule

// File: rtl/acc_cpu_alu.sv
// ALU: produces the next accumulator value from the accumulator and the
// operand word. Combinational; results wrap at the data width.
module acc_cpu_alu
    import acc_cpu_pkg::*;
(
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    input  alu_sel_t          sel,
    output logic [DATA_W-1:0] result
);
    // Select pass-through, modular add or modular subtract.
    always_comb begin
        case (sel)
            ALU_ADD: result = acc + operand;
            ALU_SUB: result = acc - operand;
            default: result = operand;
        endcase
    end
endmodule

// File: rtl/acc_cpu_core.sv
// Top: two-phase accumulator processor. Fetch cycle reads the word at PC;
// memory-operand instructions add one operand cycle. Assumes memory read
// data is combinational in the cycle its address is driven.
module acc_cpu_core
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);
    cpu_state_t        state;
    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] cur_instr;
    logic [DATA_W-1:0] alu_out;
    logic              is_mem, is_store, jump_take, is_stop;
    alu_sel_t          alu_sel;

    // Decode the fresh word in a fetch, the held word otherwise.
    assign cur_instr = (state == ST_FETCH) ? mem_rdata : ir;

    acc_cpu_decode u_dec (
        .instr     (cur_instr),
        .acc       (acc),
        .is_mem    (is_mem),
        .is_store  (is_store),
        .jump_take (jump_take),
        .is_stop   (is_stop),
        .alu_sel   (alu_sel)
    );

    acc_cpu_alu u_alu (
        .acc     (acc),
        .operand (mem_rdata),
        .sel     (alu_sel),
        .result  (alu_out)
    );

    // Memory port drive: operand address in the operand cycle, PC otherwise.
    assign mem_addr  = (state == ST_EXEC) ? ir[ADDR_W-1:0] : pc;
    assign mem_we    = (state == ST_EXEC) && is_store;
    assign mem_wdata = acc;
    assign halted    = (state == ST_HALT);

    // Sequencer: advances PC, captures instruction, updates accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH;
            pc    <= '0;
            acc   <= '0;
            ir    <= '0;
        end else begin
            case (state)
                ST_FETCH: begin
                    ir <= mem_rdata;
                    if (is_stop) begin
                        state <= ST_HALT;
                    end else if (is_mem) begin
                        state <= ST_EXEC;
                        pc    <= pc + 1'b1;
                    end else if (jump_take) begin
                        pc <= mem_rdata[ADDR_W-1:0];
                    end else begin
                        pc <= pc + 1'b1;
                    end
                end
                ST_EXEC: begin
                    if (!is_store) acc <= alu_out;
                    state <= ST_FETCH;
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    // Two consecutive write strobes would mean a missing fetch cycle.
    assert_store_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // Operand cycle is always followed by a fetch.
    assert_two_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC) |=> (state == ST_FETCH));

    // Sequential fetch increments PC.
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && !jump_take && !is_stop)
        |=> (pc == $past(pc) + 1'b1));

    // A taken jump lands on the address field.
    assert_jump_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && jump_take && !is_mem && !is_stop)
        |=> (pc == $past(mem_rdata[ADDR_W-1:0])));

    // Halt is sticky, holds the address and never writes.
    assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(mem_addr)));

    assert_halt_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);
endmodule

// File: tb/acc_cpu_core_test.sv
// Bench: behavioural reference model stepped once per clock and compared
// on every falling edge; memory lives here.
module acc_cpu_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic        halted;

    logic [15:0] mem [0:4095];

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit cmp_on  = 1'b0;

    // reference model state: 0 fetch, 1 operand, 2 halted
    int          m_st = 0;
    logic [11:0] m_pc = '0;
    logic [15:0] m_acc = '0;
    logic [15:0] m_ir = '0;

    acc_cpu_core uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted)
    );

    always #2.5 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_we === 1'b1) mem[mem_addr] <= mem_wdata;
        cycles <= cycles + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Compare outputs, then advance the model by one clock edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            logic [11:0] e_addr;
            logic        e_we;
            logic [3:0]  opc;
            e_addr = (m_st == 1) ? m_ir[11:0] : m_pc;
            e_we   = (m_st == 1) && (m_ir[15:12] == 4'd1);
            check("R2/R3 mem_addr", {20'd0, mem_addr}, {20'd0, e_addr});
            check("R4 mem_we", {31'd0, mem_we}, {31'd0, e_we});
            if (e_we) check("R4 mem_wdata", {16'd0, mem_wdata}, {16'd0, m_acc});
            check("R8 halted", {31'd0, halted}, {31'd0, (m_st == 2)});
            if (!rst_n) begin
                m_st = 0; m_pc = '0; m_acc = '0; m_ir = '0;
            end else if (m_st == 0) begin
                m_ir = mem[m_pc];
                opc  = m_ir[15:12];
                if (opc <= 4'd3) begin m_st = 1; m_pc = m_pc + 1; end
                else if (opc == 4'd4) m_pc = m_ir[11:0];
                else if (opc == 4'd5) m_pc = m_acc[15] ? m_pc + 1 : m_ir[11:0];
                else if (opc == 4'd6) m_pc = (m_acc != 0) ? m_ir[11:0] : m_pc + 1;
                else m_st = 2;
            end else if (m_st == 1) begin
                case (m_ir[15:12])
                    4'd0: m_acc = mem[m_ir[11:0]];
                    4'd2: m_acc = m_acc + mem[m_ir[11:0]];
                    4'd3: m_acc = m_acc - mem[m_ir[11:0]];
                    default: ;
                endcase
                m_st = 0;
            end
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    endtask

    // Hold reset, check the reset state (R1), release, run to halt plus idle.
    task automatic run_prog(input string name);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1;
        cmp_on = 1'b1;
        check("R1 reset addr", {20'd0, mem_addr}, 32'd0);
        check("R1 reset halted", {31'd0, halted}, 32'd0);
        check("R1 reset we", {31'd0, mem_we}, 32'd0);
        @(posedge clk); #1 rst_n = 1'b1;
        for (int k = 0; k < 400 && !halted; k++) @(posedge clk);
        for (int k = 0; k < 8; k++) @(posedge clk);
        #1;
        check({"R8 halted after ", name}, {31'd0, halted}, 32'd1);
    endtask

    initial begin
        rst_n = 1'b0;
        // Program A: add two words, store, stop (R2, R3, R4, R8)
        clear_mem();
        mem[0] = 16'h002E; mem[1] = 16'h202F; mem[2] = 16'h1030; mem[3] = 16'h7000;
        mem[12'h2E] = 16'h0123; mem[12'h2F] = 16'h7777;
        run_prog("A");
        check("R3/R4 sum stored", {16'd0, mem[12'h30]}, 32'h789A);
        check("R8 stop address held", {20'd0, mem_addr}, 32'h003);

        // Program B: countdown loop with JNZ, JGE both ways, sub/add wrap, opcode 9 stop
        clear_mem();
        mem[0]  = 16'h0020; mem[1]  = 16'h3021; mem[2]  = 16'h1022; mem[3] = 16'h6001;
        mem[4]  = 16'h5006; mem[5]  = 16'h7000; mem[6]  = 16'h3021; mem[7] = 16'h5005;
        mem[8]  = 16'h2023; mem[9]  = 16'h1024; mem[10] = 16'h400C; mem[11] = 16'h7000;
        mem[12] = 16'h9000;
        mem[12'h20] = 16'd3; mem[12'h21] = 16'd1; mem[12'h23] = 16'd1;
        mem[12'h24] = 16'h5555;
        run_prog("B");
        check("R7 loop result", {16'd0, mem[12'h22]}, 32'h0000);
        check("R3 wrap add result", {16'd0, mem[12'h24]}, 32'h0000);
        check("R8 opcode 9 stop address", {20'd0, mem_addr}, 32'h00C);

        // Program C: JNZ on negative, JGE not taken, add to 0xFFFF, opcode F stop
        clear_mem();
        mem[0] = 16'h0030; mem[1] = 16'h6003; mem[2] = 16'h7000; mem[3] = 16'h5002;
        mem[4] = 16'h2031; mem[5] = 16'h1032; mem[6] = 16'hF000;
        mem[12'h30] = 16'h8000; mem[12'h31] = 16'h7FFF;
        run_prog("C");
        check("R6 fallthrough store", {16'd0, mem[12'h32]}, 32'hFFFF);
        check("R8 opcode F stop address", {20'd0, mem_addr}, 32'h006);

        // Program D: unconditional jump skips a store (R5)
        clear_mem();
        mem[0] = 16'h0010; mem[1] = 16'h4003; mem[2] = 16'h1011; mem[3] = 16'h1012;
        mem[4] = 16'h7000; mem[12'h10] = 16'hABCD; mem[12'h11] = 16'h1111;
        run_prog("D");
        check("R5 skipped store untouched", {16'd0, mem[12'h11]}, 32'h1111);
        check("R5 target store", {16'd0, mem[12'h12]}, 32'hABCD);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule